// File: doc/BRIEF.md
# DDR Lane Deserializer, One Bit to Eight

This block takes a single double-data-rate serial lane and the clock that the sending MAC forwards with it, and assembles the bit stream into 8-bit parallel words. One lane carries a bit on every clock edge, so a 156.25 MHz lane clock moves 312.5 Mb/s. One flop samples the line on the rising edge and another samples it on the falling edge. The rising-edge bits make up the even stream and the falling-edge bits make up the odd stream. Each stream shifts into its own 4-bit register on the rising edge. The two registers are interleaved into one word, which is registered once every four lane cycles. That is one quarter of the lane clock, or 39.0625 MHz.

The word boundary is fixed from reset. The first rising-edge bit after reset is bit 0 of the first word, and a free-running pair counter marks each later word. A single-cycle `wordValid` pulse marks each new word. A wide parallel interface is built by placing one copy of this block per line, for example 32 data lines and 4 control lines, all sharing the same forwarded clock.

Top module: `ddr_lane_deser`

## Requirements
- R1: While `rstN` is low, `wordOut` is 0 and `wordValid` is 0.
- R2: The bit sampled on the rising edge of lane cycle k of a word (k = 0..3) appears at `wordOut` bit 2k.
- R3: The bit sampled on the falling edge of lane cycle k of a word (k = 0..3) appears at `wordOut` bit 2k+1.
- R4: Call edge 0 the first rising edge at which `rstN` is high. Word n holds the bits sampled in lane cycles 4n to 4n+3, with the rising bit of cycle 4n at bit 0. Words come out in order and none is skipped.
- R5: The first word is loaded at rising edge 5, so `wordValid` is first high in the cycle that follows edge 5. Word n is loaded at edge 5+4n.
- R6: `wordValid` is high for exactly one lane cycle out of every four and is never high in two consecutive cycles.
- R7: `wordOut` holds its value in every cycle in which `wordValid` is low.
- R8: Asserting `rstN` in the middle of a word discards the partial word. After release, alignment restarts with the first rising-edge bit as bit 0 of a new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| laneClk | input | 1 | Forwarded lane clock; data is valid on both edges |
| rstN | input | 1 | Asynchronous active-low reset |
| serIn | input | 1 | Serial DDR data line |
| wordOut | output | WORD_BITS (8) | Assembled word; even bits come from rising edges, odd bits from falling edges |
| wordValid | output | 1 | One-cycle pulse when a new word is loaded into `wordOut` |

## Verification
The bench fills words of only even ones (0x55) and only odd ones (0xAA). A design that swapped the two capture paths, or shifted them in the wrong direction, would scramble these words and break R2 or R3. Single-bit words 0x01 and 0x80 expose an off-by-one in the word boundary or a bit order that runs backwards. The bench counts cycles from reset release and expects the first pulse exactly after edge 5, so a design with an extra or a missing retiming stage shows up at once. A reset taken two pairs into a word checks that no leftover half-word leaks into the first word after restart.

// File: rtl/lane_deser_pkg.sv
`timescale 1ns/1ps
package lane_deser_pkg;
  // two capture phases per lane clock: rising (even) and falling (odd)
  localparam int PHASES = 2;

  typedef struct packed {
    logic shiftEn;  // advance both phase shift registers
    logic loadEn;   // copy the interleaved word into the output register
  } deser_strobe_t;
endpackage

// File: rtl/lane_deser_ctrl.sv
`timescale 1ns/1ps
module lane_deser_ctrl
  import lane_deser_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  output deser_strobe_t strb
);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DEPTH - 1);

  logic             primed;    // first pair has been captured
  logic [CNT_W-1:0] slotCnt;   // pairs shifted into the current word
  logic             loadPend;  // shift registers became full last edge

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed   <= 1'b0;
      slotCnt  <= '0;
      loadPend <= 1'b0;
    end else begin
      primed   <= 1'b1;
      loadPend <= primed && (slotCnt == LAST_SLOT);
      if (primed) begin
        slotCnt <= (slotCnt == LAST_SLOT) ? '0 : slotCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.shiftEn = primed;
    strb.loadEn  = loadPend;
  end
endmodule

// File: rtl/lane_deser_path.sv
`timescale 1ns/1ps
module lane_deser_path
  import lane_deser_pkg::*;
#(
  parameter int WORD_BITS = 8,
  parameter int DEPTH     = WORD_BITS / PHASES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serIn,
  input  deser_strobe_t        strb,
  output logic [WORD_BITS-1:0] wordOut,
  output logic                 wordValid
);
  logic riseCap;  // even bit, sampled on the rising edge
  logic fallCap;  // odd bit, sampled on the falling edge

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) riseCap <= 1'b0;
    else       riseCap <= serIn;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallCap <= 1'b0;
    else       fallCap <= serIn;
  end

  // index 0 = even stream, index 1 = odd stream
  logic [PHASES-1:0] capBit;
  assign capBit = {fallCap, riseCap};

  // both streams advance on the rising edge; this retimes the odd bit
  logic [PHASES-1:0][DEPTH-1:0] phaseSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseSr <= '0;
    end else if (strb.shiftEn) begin
      for (int ph = 0; ph < PHASES; ph++) begin
        phaseSr[ph] <= {capBit[ph], phaseSr[ph][DEPTH-1:1]};
      end
    end
  end

  // interleave: slot i of phase ph lands at word bit PHASES*i+ph
  logic [WORD_BITS-1:0] merged;
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    for (genvar ph = 0; ph < PHASES; ph++) begin : g_phase
      assign merged[PHASES*i+ph] = phaseSr[ph][i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= strb.loadEn;
      if (strb.loadEn) wordOut <= merged;
    end
  end
endmodule

// File: rtl/ddr_lane_deser.sv
`timescale 1ns/1ps
module ddr_lane_deser
  import lane_deser_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic                 laneClk,
  input  logic                 rstN,
  input  logic                 serIn,
  output logic [WORD_BITS-1:0] wordOut,
  output logic                 wordValid
);
  localparam int DEPTH = WORD_BITS / PHASES;
  localparam int CNT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  deser_strobe_t strb;

  lane_deser_ctrl #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk  (laneClk),
    .rstN (rstN),
    .strb (strb)
  );

  lane_deser_path #(
    .WORD_BITS (WORD_BITS),
    .DEPTH     (DEPTH)
  ) u_path (
    .clk       (laneClk),
    .rstN      (rstN),
    .serIn     (serIn),
    .strb      (strb),
    .wordOut   (wordOut),
    .wordValid (wordValid)
  );
endmodule

// File: rtl/lane_deser_checker.sv
`timescale 1ns/1ps
module lane_deser_checker #(
  parameter int WORD_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wordValid,
  input logic                 loadEn,
  input logic [WORD_BITS-1:0] wordOut
);
  logic [3:0] cycCnt;     // edges since reset release, saturating
  logic [3:0] sinceWord;  // edges since the last observed pulse, saturating
  logic       seenWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt    <= '0;
      sinceWord <= '0;
      seenWord  <= 1'b0;
    end else begin
      if (cycCnt != 4'hF) cycCnt <= cycCnt + 1'b1;
      if (wordValid) begin
        seenWord  <= 1'b1;
        sinceWord <= 4'd1;
      end else if (sinceWord != 4'hF) begin
        sinceWord <= sinceWord + 1'b1;
      end
    end
  end

  // R1: outputs are clear while reset is held
  always @(negedge clk) begin
    if (rstN === 1'b0) begin
      assert_reset_clear_R1: assert (wordValid == 1'b0 && wordOut == '0)
        else $error("R1 outputs not clear in reset");
    end
  end

  // R5: first pulse follows the sixth rising edge after release
  assert_first_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !seenWord) |-> (cycCnt == 4'd6));

  // R5: a load request from control becomes the pulse one edge later
  assert_load_to_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> wordValid);

  // R6: pulses are single-cycle
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R6: pulses are exactly four cycles apart
  assert_word_period_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && seenWord) |-> (sinceWord == 4'd4));

  // R7: word holds between pulses
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> $stable(wordOut));
endmodule

bind ddr_lane_deser lane_deser_checker #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk       (laneClk),
  .rstN      (rstN),
  .wordValid (wordValid),
  .loadEn    (strb.loadEn),
  .wordOut   (wordOut)
);

// File: tb/sim_ddr_lane_deser.sv
`timescale 1ns/1ps
module sim_ddr_lane_deser;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN;
  logic         serIn;
  logic [W-1:0] wordOut;
  logic         wordValid;

  int           checks = 0;
  int           errors = 0;
  int           edgeIdx;
  logic [W-1:0] expQ[$];
  logic [W-1:0] lastWord = '0;
  bit           draining = 1'b1;
  bit           finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ddr_lane_deser #(.WORD_BITS(W)) u0 (
    .laneClk   (clk),
    .rstN      (rstN),
    .serIn     (serIn),
    .wordOut   (wordOut),
    .wordValid (wordValid)
  );

  // rising edges seen since reset release (edge 0 makes it 1)
  always @(posedge clk or negedge rstN) begin
    if (!rstN) edgeIdx <= 0;
    else       edgeIdx <= edgeIdx + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one lane cycle: even bit before the rising edge, odd bit before the falling edge
  task automatic drivePair(input logic e, input logic o);
    serIn = e;
    @(posedge clk); #1;
    serIn = o;
    @(negedge clk); #1;
  endtask

  task automatic sendWord(input logic [W-1:0] w);
    expQ.push_back(w);
    for (int i = 0; i < W/2; i++) drivePair(w[2*i], w[2*i+1]);
  endtask

  task automatic startStream();
    @(negedge clk); #1;
    rstN = 1'b1;
    draining = 1'b0;
  endtask

  task automatic drainCheck(input string tag);
    repeat (3) @(negedge clk);
    #1;
    chk(expQ.size() == 0, "R4", {tag, " words left undelivered"}, expQ.size(), 0);
    draining = 1'b1;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN === 1'b0) begin
      chk(wordOut == '0 && wordValid == 1'b0, "R1", "outputs in reset",
          {wordValid, wordOut}, 0);
      lastWord = '0;
    end else if (rstN === 1'b1 && !draining) begin
      automatic bit slot = (edgeIdx >= 6) && ((edgeIdx - 6) % 4 == 0);
      chk(wordValid == slot, (edgeIdx <= 6) ? "R5" : "R6", "pulse timing",
          wordValid, slot);
      if (wordValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R4", "word with no expected entry", wordOut, 0);
        end else begin
          automatic logic [W-1:0] exp = expQ.pop_front();
          chk((wordOut & 8'h55) == (exp & 8'h55), "R2", "even bits", wordOut & 8'h55, exp & 8'h55);
          chk((wordOut & 8'hAA) == (exp & 8'hAA), "R3", "odd bits", wordOut & 8'hAA, exp & 8'hAA);
          chk(wordOut == exp, "R4", "word order", wordOut, exp);
        end
        lastWord = wordOut;
      end else begin
        chk(wordOut == lastWord, "R7", "hold between pulses", wordOut, lastWord);
      end
    end
  end

  initial begin
    rstN  = 1'b0;
    serIn = 1'b0;
    repeat (3) @(negedge clk);

    // directed patterns, then a computed stream
    startStream();
    sendWord(8'h01);  // R4: only bit 0
    sendWord(8'h80);  // R4: only bit 7
    sendWord(8'h55);  // R2: only rising-edge bits
    sendWord(8'hAA);  // R3: only falling-edge bits
    sendWord(8'hFF);
    sendWord(8'h00);
    sendWord(8'hA5);
    sendWord(8'h3C);
    for (int n = 0; n < 40; n++) sendWord(8'((n * 37 + 11) ^ (n << 3)));
    drainCheck("first stream");

    // R8: reset two pairs into a word, then restart
    @(negedge clk); #1;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    startStream();
    sendWord(8'h96);
    sendWord(8'h69);
    drivePair(1'b1, 1'b1);
    drivePair(1'b1, 1'b0);
    draining = 1'b1;
    rstN = 1'b0;
    chk(expQ.size() == 0, "R8", "words pending at mid-word reset", expQ.size(), 0);
    repeat (3) @(negedge clk);
    startStream();
    sendWord(8'hC3);  // R8: must not contain the discarded half-word
    sendWord(8'h0F);
    sendWord(8'hF0);
    drainCheck("after mid-word reset R8");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule